// File: doc/BRIEF.md
# Descriptor-Chained Quad SPI DMA Engine

This block is the memory-side front end of a half-duplex quad SPI controller. Software lays out a linked list of command descriptors in memory, sets the DMA enable bit in the configuration register and writes the address of the first descriptor to the chain-start register. The engine then works through the list on its own. For each entry it reads three words over a single-outstanding 32-bit memory port, checks the buffer alignment and announces one transfer command to the downstream serializer: direction, lane mode, fragment flag and byte count. It then moves the payload one byte at a time, either from memory to the serializer or from the serializer into memory.

When the next-pointer word of a finished descriptor is zero, the chain is complete and a status bit is raised. If a buffer address is misaligned or the memory answers a request with an error, the chain stops and one of two error bits is raised instead. Any status bit can drive the interrupt line through its own enable bit. Software clears status bits by writing ones to them.

Top module: `qdma_chain_engine`

## Requirements
- R1: A descriptor at address P is read as three words in a fixed sequence: the buffer address at P, the next-descriptor address at P+4, then the control word at P+8. The memory port never issues a new request while an earlier one is still waiting for its response.
- R2: Control word fields are: bit 0 direction (1 = memory to serializer, 0 = serializer to memory), bits 3:1 lane mode, bit 8 fragment (1 = the SPI transfer continues in the next descriptor), bits 31:16 byte length. All other bits are ignored. Each accepted descriptor produces exactly one cmd_valid pulse carrying these fields.
- R3: Lane mode codes 1, 2 and 3 (one, two and four lanes) are passed through unchanged on cmd_mode. Every other code is issued as 1.
- R4: A length field of N > 0 moves exactly N bytes and reports cmd_len = N. A length field of 0 reports cmd_len = 65536.
- R5: In direction 1, the bytes at buffer addresses A, A+1, … are read from memory and appear on tx_byte in ascending address order, one per tx_valid/tx_ready handshake. The byte at address a is bits 8*(a mod 4)+7 down to 8*(a mod 4) of the word at a with its two low bits cleared.
- R6: In direction 0, each byte accepted with rx_valid/rx_ready is written to the next ascending buffer address. The write uses only the byte enable of that byte's lane, and neighbouring bytes are left unchanged.
- R7: After each descriptor, the engine continues at its next-descriptor address. A next address of 0, including a start write of 0, ends the chain and sets status bit 31.
- R8: A write to offset 0x40 starts a chain only while bit 0 of the configuration register (offset 0x00) is 1. Otherwise no memory request follows and the status is unchanged.
- R9: A buffer address whose five low bits are not all zero stops the chain. It issues no command for that descriptor, sets status bit 1 and leaves bit 31 clear.
- R10: A memory response with mem_err high, during descriptor fetch or data movement, stops the chain. It sets status bit 2, leaves bit 31 clear and moves no further data.
- R11: The status register is at offset 0x10 and the enable register at offset 0x0C. irq is high exactly when some status bit and the same enable bit are both 1. Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged.
- R12: Offset 0x44 reads the address of the descriptor most recently fetched. Offset 0x48 reads the current buffer address, which after a descriptor completes is one past its last byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt line |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data (byte replicated on all lanes) |
| mem_be | output | 4 | Byte lane enables |
| mem_rsp | input | 1 | Response to the outstanding request |
| mem_err | input | 1 | Response carries an error |
| mem_rdata | input | 32 | Read data with the response |
| cmd_valid | output | 1 | One-cycle transfer command to the serializer |
| cmd_dir | output | 1 | Command direction |
| cmd_mode | output | 3 | Lane mode after fallback |
| cmd_frag | output | 1 | Transfer continues after this command |
| cmd_len | output | 17 | Byte count of the command |
| tx_valid | output | 1 | Byte offered to the serializer |
| tx_byte | output | 8 | Byte to the serializer |
| tx_ready | input | 1 | Serializer takes the byte |
| rx_valid | input | 1 | Serializer offers a byte |
| rx_byte | input | 8 | Byte from the serializer |
| rx_ready | output | 1 | Engine takes the byte |

## Verification
A wrong fetch index or next-pointer latch shows up at the ports within one descriptor. Either the three request addresses break the P, P+4, P+8 pattern, or the following command carries fields from the wrong word. A byte counter that is off by one moves the completion bit and the reported buffer address by a single byte, so checking offset 0x48 and the exact byte count catches it when the descriptor ends. A misplaced byte-lane select shows as a wrong value in the tx stream, or as a damaged neighbouring byte in memory, on the first byte that is not word aligned.

// File: rtl/qdma_pkg.sv
package qdma_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int LANES      = DATA_W / 8;
  localparam int LANE_W     = $clog2(LANES);
  localparam int LEN_W      = 16;
  localparam int CNT_W      = LEN_W + 1;
  localparam int ALIGN_BITS = 5;
  localparam int RA_W       = 8;

  localparam logic [RA_W-1:0] OFF_CFG  = 8'h00;
  localparam logic [RA_W-1:0] OFF_IEN  = 8'h0C;
  localparam logic [RA_W-1:0] OFF_STAT = 8'h10;
  localparam logic [RA_W-1:0] OFF_NEXT = 8'h40;
  localparam logic [RA_W-1:0] OFF_CURD = 8'h44;
  localparam logic [RA_W-1:0] OFF_CURM = 8'h48;

  localparam int ST_DONE  = 31;
  localparam int ST_ALIGN = 1;
  localparam int ST_BUS   = 2;

  localparam logic [2:0] LANE_X1 = 3'd1;
  localparam logic [2:0] LANE_X2 = 3'd2;
  localparam logic [2:0] LANE_X4 = 3'd3;

  // unsupported lane codes fall back to one lane
  function automatic logic [2:0] lane_fix(input logic [2:0] m);
    return (m == LANE_X1 || m == LANE_X2 || m == LANE_X4) ? m : LANE_X1;
  endfunction

  // zero length field stands for the full 2^LEN_W bytes
  function automatic logic [CNT_W-1:0] byte_count(input logic [LEN_W-1:0] f);
    return (f == '0) ? (CNT_W'(1) << LEN_W) : {1'b0, f};
  endfunction

  function automatic logic addr_aligned(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] mask;
    mask = (ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1);
    return (a & mask) == '0;
  endfunction

  function automatic logic [LANES-1:0] lane_be(input logic [LANE_W-1:0] lane);
    return LANES'(1) << lane;
  endfunction

  function automatic logic [7:0] pick_byte(input logic [DATA_W-1:0] w,
                                           input logic [LANE_W-1:0] lane);
    logic [DATA_W-1:0] sh;
    sh = w >> (8 * lane);
    return sh[7:0];
  endfunction
endpackage

// File: rtl/qdma_regs.sv
module qdma_regs
  import qdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              busy,
  input  logic              evt_done,
  input  logic              evt_align,
  input  logic              evt_bus,
  input  logic [ADDR_W-1:0] cur_desc,
  input  logic [ADDR_W-1:0] cur_mem,
  output logic              dma_en,
  output logic              kick,
  output logic [ADDR_W-1:0] kick_ptr
);
  logic              en_q;
  logic [DATA_W-1:0] ien_q;
  logic [DATA_W-1:0] stat_q;
  logic [ADDR_W-1:0] next_q;
  logic [DATA_W-1:0] stat_set;
  logic [DATA_W-1:0] stat_clr;

  always_comb begin
    stat_set = '0;
    stat_set[ST_DONE]  = evt_done;
    stat_set[ST_ALIGN] = evt_align;
    stat_set[ST_BUS]   = evt_bus;
    stat_clr = (reg_wr && reg_addr == OFF_STAT) ? reg_wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ien_q  <= '0;
      stat_q <= '0;
      next_q <= '0;
    end else begin
      if (reg_wr && reg_addr == OFF_CFG)  en_q   <= reg_wdata[0];
      if (reg_wr && reg_addr == OFF_IEN)  ien_q  <= reg_wdata;
      if (reg_wr && reg_addr == OFF_NEXT) next_q <= reg_wdata;
      stat_q <= (stat_q & ~stat_clr) | stat_set;
    end
  end

  assign dma_en   = en_q;
  assign kick     = reg_wr && reg_addr == OFF_NEXT && en_q && !busy;
  assign kick_ptr = reg_wdata;
  assign irq      = |(stat_q & ien_q);

  always_comb begin
    unique case (reg_addr)
      OFF_CFG:  reg_rdata = {{(DATA_W-1){1'b0}}, en_q};
      OFF_IEN:  reg_rdata = ien_q;
      OFF_STAT: reg_rdata = stat_q;
      OFF_NEXT: reg_rdata = next_q;
      OFF_CURD: reg_rdata = cur_desc;
      OFF_CURM: reg_rdata = cur_mem;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/qdma_sequencer.sv
module qdma_sequencer
  import qdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic [ADDR_W-1:0] kick_ptr,
  output logic              f_req,
  output logic [ADDR_W-1:0] f_addr,
  input  logic              mem_rsp,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              cmd_valid,
  output logic              cmd_dir,
  output logic [2:0]        cmd_mode,
  output logic              cmd_frag,
  output logic [CNT_W-1:0]  cmd_len,
  output logic [ADDR_W-1:0] mv_addr,
  input  logic              mv_done,
  input  logic              mv_err,
  output logic              owns_mem,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_desc,
  output logic              evt_done,
  output logic              evt_align,
  output logic              evt_bus
);
  typedef enum logic [2:0] {
    S_IDLE, S_NEXT, S_FREQ, S_FWAIT, S_DECODE, S_MOVE
  } seq_state_t;

  seq_state_t        state_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] desc_q;
  logic [1:0]        widx_q;
  logic [ADDR_W-1:0] data_q;
  logic [ADDR_W-1:0] link_q;
  logic              dir_q;
  logic [2:0]        mode_q;
  logic              frag_q;
  logic [LEN_W-1:0]  len_q;
  logic              buf_ok;
  logic              chain_end;
  logic              fetch_rsp;

  assign buf_ok    = addr_aligned(data_q);
  assign chain_end = state_q == S_NEXT && ptr_q == '0;
  assign fetch_rsp = state_q == S_FWAIT && mem_rsp;

  assign f_req     = state_q == S_FREQ;
  assign f_addr    = desc_q + {{(ADDR_W-4){1'b0}}, widx_q, 2'b00};
  assign cmd_valid = state_q == S_DECODE && buf_ok;
  assign cmd_dir   = dir_q;
  assign cmd_mode  = lane_fix(mode_q);
  assign cmd_frag  = frag_q;
  assign cmd_len   = byte_count(len_q);
  assign mv_addr   = data_q;
  assign owns_mem  = state_q != S_MOVE;
  assign busy      = state_q != S_IDLE;
  assign cur_desc  = desc_q;
  assign evt_done  = chain_end;
  assign evt_align = state_q == S_DECODE && !buf_ok;
  assign evt_bus   = (fetch_rsp && mem_err) || (state_q == S_MOVE && mv_err);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      desc_q  <= '0;
      widx_q  <= '0;
      data_q  <= '0;
      link_q  <= '0;
      dir_q   <= 1'b0;
      mode_q  <= '0;
      frag_q  <= 1'b0;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (kick) begin
          ptr_q   <= kick_ptr;
          state_q <= S_NEXT;
        end
        S_NEXT: begin
          if (chain_end) state_q <= S_IDLE;
          else begin
            desc_q  <= ptr_q;
            widx_q  <= '0;
            state_q <= S_FREQ;
          end
        end
        S_FREQ: state_q <= S_FWAIT;
        S_FWAIT: if (mem_rsp) begin
          if (mem_err) state_q <= S_IDLE;
          else begin
            unique case (widx_q)
              2'd0: data_q <= mem_rdata;
              2'd1: link_q <= mem_rdata;
              default: begin
                dir_q  <= mem_rdata[0];
                mode_q <= mem_rdata[3:1];
                frag_q <= mem_rdata[8];
                len_q  <= mem_rdata[31:16];
              end
            endcase
            if (widx_q == 2'd2) state_q <= S_DECODE;
            else begin
              widx_q  <= widx_q + 2'd1;
              state_q <= S_FREQ;
            end
          end
        end
        S_DECODE: state_q <= buf_ok ? S_MOVE : S_IDLE;
        S_MOVE: begin
          if (mv_err) state_q <= S_IDLE;
          else if (mv_done) begin
            ptr_q   <= link_q;
            state_q <= S_NEXT;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qdma_mover.sv
module qdma_mover
  import qdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  count,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [LANES-1:0]  mem_be,
  input  logic              mem_rsp,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              rx_ready,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] cur_addr
);
  typedef enum logic [2:0] {
    M_IDLE, M_RDREQ, M_RDWAIT, M_TXOUT, M_RXIN, M_WRREQ, M_WRWAIT
  } mv_state_t;

  mv_state_t         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [7:0]        byte_q;
  logic              in_wait;
  logic              beat;
  logic              last;

  assign in_wait = state_q == M_RDWAIT || state_q == M_WRWAIT;
  assign last    = left_q == CNT_W'(1);
  assign beat    = (state_q == M_TXOUT && tx_ready) ||
                   (state_q == M_WRWAIT && mem_rsp && !mem_err);
  assign done    = beat && last;
  assign err     = in_wait && mem_rsp && mem_err;

  assign mem_req   = state_q == M_RDREQ || state_q == M_WRREQ;
  assign mem_we    = state_q == M_WRREQ;
  assign mem_addr  = addr_q;
  assign mem_wdata = {LANES{byte_q}};
  assign mem_be    = mem_we ? lane_be(addr_q[LANE_W-1:0]) : {LANES{1'b1}};
  assign tx_valid  = state_q == M_TXOUT;
  assign tx_byte   = byte_q;
  assign rx_ready  = state_q == M_RXIN;
  assign cur_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= M_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      byte_q  <= '0;
    end else begin
      if (beat) begin
        addr_q <= addr_q + ADDR_W'(1);
        left_q <= left_q - CNT_W'(1);
      end
      unique case (state_q)
        M_IDLE: if (start) begin
          addr_q  <= start_addr;
          left_q  <= count;
          state_q <= dir ? M_RDREQ : M_RXIN;
        end
        M_RDREQ: state_q <= M_RDWAIT;
        M_RDWAIT: if (mem_rsp) begin
          if (mem_err) state_q <= M_IDLE;
          else begin
            byte_q  <= pick_byte(mem_rdata, addr_q[LANE_W-1:0]);
            state_q <= M_TXOUT;
          end
        end
        M_TXOUT: if (tx_ready) state_q <= last ? M_IDLE : M_RDREQ;
        M_RXIN: if (rx_valid) begin
          byte_q  <= rx_byte;
          state_q <= M_WRREQ;
        end
        M_WRREQ: state_q <= M_WRWAIT;
        M_WRWAIT: if (mem_rsp) begin
          if (mem_err) state_q <= M_IDLE;
          else state_q <= last ? M_IDLE : M_RXIN;
        end
        default: state_q <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qdma_chain_engine.sv
module qdma_chain_engine
  import qdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [LANES-1:0]  mem_be,
  input  logic              mem_rsp,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              cmd_valid,
  output logic              cmd_dir,
  output logic [2:0]        cmd_mode,
  output logic              cmd_frag,
  output logic [CNT_W-1:0]  cmd_len,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              rx_ready
);
  logic              busy, dma_en, kick;
  logic [ADDR_W-1:0] kick_ptr, cur_desc, cur_mem, mv_addr, f_addr;
  logic              evt_done, evt_align, evt_bus;
  logic              f_req, owns_mem, mv_done, mv_err;
  logic              m_req, m_we;
  logic [ADDR_W-1:0] m_addr;
  logic [DATA_W-1:0] m_wdata;
  logic [LANES-1:0]  m_be;

  qdma_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .busy(busy),
    .evt_done(evt_done), .evt_align(evt_align), .evt_bus(evt_bus),
    .cur_desc(cur_desc), .cur_mem(cur_mem), .dma_en(dma_en), .kick(kick),
    .kick_ptr(kick_ptr)
  );

  qdma_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .kick(kick), .kick_ptr(kick_ptr),
    .f_req(f_req), .f_addr(f_addr), .mem_rsp(mem_rsp), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .cmd_valid(cmd_valid), .cmd_dir(cmd_dir),
    .cmd_mode(cmd_mode), .cmd_frag(cmd_frag), .cmd_len(cmd_len),
    .mv_addr(mv_addr), .mv_done(mv_done), .mv_err(mv_err),
    .owns_mem(owns_mem), .busy(busy), .cur_desc(cur_desc),
    .evt_done(evt_done), .evt_align(evt_align), .evt_bus(evt_bus)
  );

  qdma_mover u_mover (
    .clk(clk), .rst_n(rst_n), .start(cmd_valid), .dir(cmd_dir),
    .start_addr(mv_addr), .count(cmd_len), .mem_req(m_req), .mem_we(m_we),
    .mem_addr(m_addr), .mem_wdata(m_wdata), .mem_be(m_be),
    .mem_rsp(mem_rsp), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .done(mv_done), .err(mv_err), .cur_addr(cur_mem)
  );

  // memory port belongs to the fetcher except while payload moves
  assign mem_req   = owns_mem ? f_req  : m_req;
  assign mem_we    = owns_mem ? 1'b0   : m_we;
  assign mem_addr  = owns_mem ? f_addr : m_addr;
  assign mem_wdata = owns_mem ? '0     : m_wdata;
  assign mem_be    = owns_mem ? {LANES{1'b1}} : m_be;
endmodule

// File: rtl/qdma_chain_engine_chk.sv
module qdma_chain_engine_chk
  import qdma_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            mem_rsp,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic [7:0]      tx_byte,
  input logic            rx_ready,
  input logic            cmd_valid,
  input logic [2:0]      cmd_mode,
  input logic            reg_wr,
  input logic [RA_W-1:0] reg_addr,
  input logic            dma_en,
  input logic            busy,
  input logic            evt_done,
  input logic            evt_align,
  input logic            evt_bus
);
  logic pend_q;
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else if (mem_req) pend_q <= 1'b1;
    else if (mem_rsp) pend_q <= 1'b0;
  end

  a_r1_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !pend_q);
  a_r3_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_mode == LANE_X1 || cmd_mode == LANE_X2 || cmd_mode == LANE_X4));
  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));
  a_r6_rx_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !pend_q);
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> (!pend_q && !tx_valid));
  a_r8_kick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_NEXT && !dma_en && !busy) |=> !busy);
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_done, evt_align, evt_bus}));
endmodule

bind qdma_chain_engine qdma_chain_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_rsp(mem_rsp),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
  .rx_ready(rx_ready), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .dma_en(dma_en), .busy(busy),
  .evt_done(evt_done), .evt_align(evt_align), .evt_bus(evt_bus)
);

// File: tb/qdma_chain_engine_bench.sv
module qdma_chain_engine_bench;
  localparam int PERIOD = 10;
  localparam logic [31:0] ERR_BASE = 32'h0000_0F00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_rsp = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        cmd_valid, cmd_dir, cmd_frag;
  logic [2:0]  cmd_mode;
  logic [16:0] cmd_len;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_byte;
  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  rx_byte = '0;

  int checks = 0, errors = 0;

  qdma_chain_engine u_qdma_chain_engine (.*);

  always #(PERIOD/2) clk = ~clk;

  // memory model, two-cycle response
  logic [31:0] mem [0:1023];
  logic [31:0] rq_log [0:255];
  int          rq_n = 0;
  logic        p_v = 1'b0, p_we = 1'b0;
  logic [31:0] p_addr = '0, p_wdata = '0;
  logic [3:0]  p_be = '0;
  always @(posedge clk) begin
    mem_rsp <= 1'b0;
    mem_err <= 1'b0;
    if (p_v) begin
      mem_rsp <= 1'b1;
      if (p_addr >= ERR_BASE) mem_err <= 1'b1;
      else if (p_we) begin
        for (int b = 0; b < 4; b++)
          if (p_be[b]) mem[p_addr[11:2]][8*b +: 8] = p_wdata[8*b +: 8];
      end else mem_rdata <= mem[p_addr[11:2]];
    end
    p_v <= mem_req;
    if (mem_req) begin
      p_we <= mem_we; p_addr <= mem_addr; p_wdata <= mem_wdata; p_be <= mem_be;
      if (rq_n < 256) rq_log[rq_n] = mem_addr;
      rq_n = rq_n + 1;
    end
  end

  // serializer stub
  int          cyc = 0;
  logic [7:0]  tx_log [0:255];
  int          tx_n = 0;
  logic [22:0] cmd_log [0:15];
  int          cmd_n = 0;
  logic [7:0]  rx_src [0:63];
  int          rx_total = 0, rx_idx = 0;
  always @(posedge clk) begin
    int nx;
    cyc = cyc + 1;
    tx_ready <= (cyc % 4) != 3;
    if (tx_valid && tx_ready) begin
      if (tx_n < 256) tx_log[tx_n] = tx_byte;
      tx_n = tx_n + 1;
    end
    if (cmd_valid) begin
      if (cmd_n < 16) cmd_log[cmd_n] = {cmd_dir, cmd_mode, cmd_frag, cmd_len, 1'b0};
      cmd_n = cmd_n + 1;
    end
    nx = rx_idx + ((rx_valid && rx_ready) ? 1 : 0);
    rx_idx <= nx;
    rx_valid <= nx < rx_total;
    rx_byte <= rx_src[nx % 64];
  end

  function automatic logic [7:0] pat(input logic [31:0] a);
    return 8'((a * 7 + 3) & 32'hFF);
  endfunction

  function automatic logic [31:0] ctl(input logic d, input logic [2:0] m,
                                      input logic f, input logic [15:0] len);
    return {len, 7'b0, f, 4'b0, m, d};
  endfunction

  function automatic logic [22:0] cmd_exp(input logic d, input logic [2:0] m,
                                          input logic f, input logic [16:0] n);
    return {d, m, f, n, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic put_desc(input logic [31:0] p, input logic [31:0] buf_a,
                          input logic [31:0] nxt, input logic [31:0] c);
    mem[p[11:2]]     = buf_a;
    mem[p[11:2] + 1] = nxt;
    mem[p[11:2] + 2] = c;
  endtask

  task automatic wait_end(output logic [31:0] st);
    st = '0;
    for (int i = 0; i < 5000; i++) begin
      reg_read(8'h10, st);
      if ((st & 32'h8000_0006) != 0) break;
    end
    repeat (3) @(negedge clk);
    reg_read(8'h10, st);
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    logic [31:0] w;
    w = mem[a[11:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    reg_read(8'h10, v); chk("R11 reset status", v, 0);
    chk("R11 reset irq", {31'b0, irq}, 0);
    reg_read(8'h48, v); chk("R12 reset cur mem", v, 0);
  endtask

  task automatic t_disabled_kick();
    logic [31:0] v;
    int r0 = rq_n;
    reg_write(8'h00, 0);
    reg_write(8'h40, 32'h100);
    repeat (30) @(negedge clk);
    chk("R8 no request when disabled", rq_n - r0, 0);
    reg_read(8'h10, v); chk("R8 status untouched", v, 0);
  endtask

  task automatic t_empty_chain();
    logic [31:0] v;
    int r0 = rq_n;
    reg_write(8'h00, 1);
    reg_read(8'h00, v); chk("R8 enable readback", v, 1);
    reg_write(8'h40, 0);
    wait_end(v);
    chk("R7 zero start sets done", v, 32'h8000_0000);
    chk("R7 zero start no fetch", rq_n - r0, 0);
    reg_write(8'h10, 32'hFFFF_FFFF);
  endtask

  task automatic t_tx_chain();
    logic [31:0] v;
    int r0 = rq_n, t0 = tx_n, c0 = cmd_n;
    put_desc(32'h100, 32'h400, 32'h120, ctl(1'b1, 3'd3, 1'b1, 16'd5));
    put_desc(32'h120, 32'h440, 32'h000, ctl(1'b1, 3'd5, 1'b0, 16'd3));
    reg_write(8'h0C, 32'h8000_0000);
    reg_write(8'h40, 32'h100);
    wait_end(v);
    chk("R7 chain done", v, 32'h8000_0000);
    chk("R11 irq enabled", {31'b0, irq}, 1);
    chk("R1 fetch word 0", rq_log[r0], 32'h100);
    chk("R1 fetch word 1", rq_log[r0 + 1], 32'h104);
    chk("R1 fetch word 2", rq_log[r0 + 2], 32'h108);
    chk("R2 command count", cmd_n - c0, 2);
    chk("R2 first command", 32'(cmd_log[c0]), 32'(cmd_exp(1'b1, 3'd3, 1'b1, 17'd5)));
    chk("R3 fallback mode", 32'(cmd_log[c0 + 1]), 32'(cmd_exp(1'b1, 3'd1, 1'b0, 17'd3)));
    chk("R4 R5 byte count", tx_n - t0, 8);
    for (int k = 0; k < 5; k++) chk("R5 tx byte d0", 32'(tx_log[t0 + k]), 32'(pat(32'h400 + k)));
    for (int k = 0; k < 3; k++) chk("R5 tx byte d1", 32'(tx_log[t0 + 5 + k]), 32'(pat(32'h440 + k)));
    reg_read(8'h44, v); chk("R12 current descriptor", v, 32'h120);
    reg_read(8'h48, v); chk("R12 current memory", v, 32'h443);
  endtask

  task automatic t_status_clear();
    logic [31:0] v;
    reg_write(8'h10, 32'h0000_0006);
    reg_read(8'h10, v); chk("R11 write zero keeps bit", v, 32'h8000_0000);
    reg_write(8'h10, 32'h8000_0000);
    reg_read(8'h10, v); chk("R11 write one clears", v, 0);
    chk("R11 irq drops", {31'b0, irq}, 0);
  endtask

  task automatic t_rx_chain();
    logic [31:0] v;
    int c0 = cmd_n;
    reg_write(8'h0C, 0);
    put_desc(32'h200, 32'h480, 32'h000, ctl(1'b0, 3'd2, 1'b0, 16'd6));
    for (int k = 0; k < 6; k++) rx_src[(rx_total + k) % 64] = 8'hA0 + 8'(k);
    rx_total = rx_total + 6;
    reg_write(8'h40, 32'h200);
    wait_end(v);
    chk("R7 rx chain done", v, 32'h8000_0000);
    chk("R11 masked irq", {31'b0, irq}, 0);
    chk("R2 rx command", 32'(cmd_log[c0]), 32'(cmd_exp(1'b0, 3'd2, 1'b0, 17'd6)));
    for (int k = 0; k < 6; k++) chk("R6 rx byte stored", 32'(mem_byte(32'h480 + k)), 32'hA0 + k);
    chk("R6 neighbour kept", 32'(mem_byte(32'h486)), 32'(pat(32'h486)));
    reg_read(8'h48, v); chk("R12 rx end address", v, 32'h486);
    reg_write(8'h10, 32'hFFFF_FFFF);
  endtask

  task automatic t_misaligned();
    logic [31:0] v;
    int c0 = cmd_n, t0 = tx_n;
    put_desc(32'h220, 32'h404, 32'h000, ctl(1'b1, 3'd1, 1'b0, 16'd4));
    reg_write(8'h40, 32'h220);
    wait_end(v);
    chk("R9 align error only", v, 32'h0000_0002);
    chk("R9 no command", cmd_n - c0, 0);
    chk("R9 no data", tx_n - t0, 0);
    reg_write(8'h10, 32'hFFFF_FFFF);
  endtask

  task automatic t_len_zero_fault();
    logic [31:0] v;
    int c0 = cmd_n, t0 = tx_n;
    put_desc(32'h240, 32'hEE0, 32'h100, ctl(1'b1, 3'd1, 1'b0, 16'd0));
    reg_write(8'h0C, 32'h0000_0004);
    reg_write(8'h40, 32'h240);
    wait_end(v);
    chk("R4 zero length command", 32'(cmd_log[c0]), 32'(cmd_exp(1'b1, 3'd1, 1'b0, 17'h10000)));
    chk("R10 bus error only", v, 32'h0000_0004);
    chk("R10 irq on error", {31'b0, irq}, 1);
    chk("R10 bytes before fault", tx_n - t0, 32);
    for (int k = 0; k < 32; k++) chk("R5 tx byte before fault", 32'(tx_log[t0 + k]), 32'(pat(32'hEE0 + k)));
    repeat (20) @(negedge clk);
    chk("R10 nothing after fault", tx_n - t0, 32);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++)
      mem[i] = {pat(4*i + 3), pat(4*i + 2), pat(4*i + 1), pat(4*i)};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled_kick();
    t_empty_chain();
    t_tx_chain();
    t_status_clear();
    t_rx_chain();
    t_misaligned();
    t_len_zero_fault();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule